// File: doc/BRIEF.md
# Separable 3x3 Box Blur Pipeline

This block is a streaming image filter for unsigned 16-bit pixels delivered in raster order, one row of fixed width `W` after another. Each pass of the filter is split in two: a horizontal stage replaces every pixel with the integer mean of itself and its left and right neighbours. A vertical stage then takes the integer mean of three vertically adjacent horizontal results. The vertical stage keeps the two most recent rows of horizontal results in on-chip row storage. The number of rows in an image is never configured. The end of an image is marked by a flag on its final input beat.

Both streams move `P` pixels per beat with a valid/ready handshake. A beat moves on a rising clock edge where valid and ready are both high. Once the block raises `out_valid`, it holds `out_data` and `out_last` steady until the beat is taken. A low `out_ready` stalls the whole pipeline without losing or repeating a pixel. `in_ready` may fall whenever downstream space runs out, and also while the block emits the final row of an image. The upstream source must hold its beat until it is accepted.

`ITER` copies of the two-stage pass are chained, so the output of one pass is the input of the next. The block emits exactly as many pixels as it receives, in the same raster order.

Top module: `boxblur_top`

## Requirements
- R1: Each mean is the sum of three 16-bit values, computed at 18 bits so it never overflows, divided by 3 with truncation. An image of all 0xFFFF pixels comes out as all 0xFFFF.
- R2: In the horizontal stage, a pixel in column 0 or column W-1 is passed through unchanged. Every other pixel becomes the mean of columns x-1, x and x+1 of its own row.
- R3: In the vertical stage, a pixel in a row that is neither the first nor the last row of the image becomes the mean of the horizontal results at rows y-1, y and y+1 of the same column.
- R4: In the vertical stage, the first and the last row of the image are passed through unchanged. An image of a single row is passed through by the vertical stage.
- R5: The number of output pixels equals the number of input pixels. `out_last` is high only on the final output beat of an image.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` keep their values on the next clock edge.
- R7: The complete two-stage filter is applied `ITER` times in sequence. Pass k+1 receives the full output image of pass k.
- R8: A beat carries P horizontally adjacent pixels. Lane i holds pixel x = beat*P + i of the row, and lane 0 sits in the least significant 16 bits. Rows are W/P beats long.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: `in_last` marks the final beat of an image, which is also the final beat of a row. The next beat starts a new image whose first row is again treated as a border row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | P*16 | Input pixels, lane 0 in the low bits |
| in_last | input | 1 | Final beat of the input image |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer can take an output beat |
| out_data | output | P*16 | Output pixels, lane 0 in the low bits |
| out_last | output | 1 | Final beat of the output image |

## Verification
The hardest case to reach from the ports arises at the end of an image. The vertical stage of the first pass emits the final row on its own while the second pass is still filling its row storage. If the consumer stalls at that moment, the ready signal has to travel back through every stage. The bench sends images of one, two and several rows back to back with no reset between them. It randomizes `out_ready` at several duty levels, so stalls fall on row ends and on these self-driven final rows, and it checks every pixel against a model that uses the same border rules. It runs two instances, one with two lanes and one with a single lane, and adds a long directed stall to check that held output stays stable.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int PW = 16;
  localparam int SW = PW + 2;

  function automatic logic [PW-1:0] avg3(input logic [PW-1:0] a,
                                         input logic [PW-1:0] b,
                                         input logic [PW-1:0] c);
    logic [SW-1:0] s;
    s = {2'b00, a} + {2'b00, b} + {2'b00, c};
    return PW'(s / SW'(3));
  endfunction
endpackage

// File: rtl/bb_hpass.sv
module bb_hpass
  import bb_pkg::*;
#(
  parameter int W = 2000,
  parameter int P = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [P*PW-1:0] in_data,
  input  logic            in_last,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [P*PW-1:0] out_data,
  output logic            out_last
);
  localparam int BEATS = W / P;
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic            cur_v;
  logic [P*PW-1:0] cur;
  logic            cur_last;
  logic [CW-1:0]   cur_col;
  logic [CW-1:0]   in_col;
  logic [PW-1:0]   lft;
  logic            row_end, acc, fire;

  assign row_end   = (cur_col == CW'(BEATS - 1));
  assign out_valid = cur_v && (row_end || in_valid);
  assign in_ready  = !cur_v || out_ready;
  assign acc       = in_valid && in_ready;
  assign fire      = out_valid && out_ready;
  assign out_last  = cur_last;

  for (genvar g = 0; g < P; g++) begin : g_lane
    logic [PW-1:0] left_px, right_px, mid_px;
    logic          border;
    assign mid_px = cur[g*PW +: PW];
    if (g == 0) begin : g_l0
      assign left_px = lft;
    end else begin : g_ln
      assign left_px = cur[(g-1)*PW +: PW];
    end
    if (g == P - 1) begin : g_rl
      assign right_px = in_data[0 +: PW];
    end else begin : g_rn
      assign right_px = cur[(g+1)*PW +: PW];
    end
    assign border = ((g == 0) && (cur_col == '0)) || ((g == P - 1) && row_end);
    assign out_data[g*PW +: PW] = border ? mid_px : avg3(left_px, mid_px, right_px);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_v    <= 1'b0;
      cur      <= '0;
      cur_last <= 1'b0;
      cur_col  <= '0;
      in_col   <= '0;
      lft      <= '0;
    end else begin
      cur_v <= acc || (cur_v && !fire);
      if (acc) begin
        cur      <= in_data;
        cur_last <= in_last;
        cur_col  <= in_col;
        in_col   <= (in_col == CW'(BEATS - 1)) ? '0 : in_col + 1'b1;
      end
      if (fire) lft <= cur[(P-1)*PW +: PW];
    end
  end
endmodule

// File: rtl/bb_vpass.sv
module bb_vpass
  import bb_pkg::*;
#(
  parameter int W = 2000,
  parameter int P = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [P*PW-1:0] in_data,
  input  logic            in_last,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [P*PW-1:0] out_data,
  output logic            out_last
);
  localparam int BEATS = W / P;
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [P*PW-1:0] row_old [BEATS];
  logic [P*PW-1:0] row_new [BEATS];

  logic [CW-1:0]   col;
  logic [1:0]      rowcnt;
  logic            flushing;
  logic            ov, olast;
  logic [P*PW-1:0] od;
  logic            rdy_int, acc, step, pre_valid, col_end, pass_row;
  logic [P*PW-1:0] prev, prev2, nxt;

  assign rdy_int   = !ov || out_ready;
  assign in_ready  = !flushing && ((rowcnt == 2'd0) || rdy_int);
  assign acc       = in_valid && in_ready;
  assign step      = flushing ? rdy_int : acc;
  assign pre_valid = flushing || (in_valid && (rowcnt != 2'd0));
  assign col_end   = (col == CW'(BEATS - 1));
  assign pass_row  = flushing || (rowcnt == 2'd1);
  assign prev      = row_new[col];
  assign prev2     = row_old[col];

  for (genvar g = 0; g < P; g++) begin : g_lane
    assign nxt[g*PW +: PW] = pass_row ? prev[g*PW +: PW]
                           : avg3(prev2[g*PW +: PW], prev[g*PW +: PW], in_data[g*PW +: PW]);
  end

  assign out_valid = ov;
  assign out_data  = od;
  assign out_last  = olast;

  always_ff @(posedge clk) begin
    if (acc) begin
      row_old[col] <= row_new[col];
      row_new[col] <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col      <= '0;
      rowcnt   <= 2'd0;
      flushing <= 1'b0;
      ov       <= 1'b0;
      olast    <= 1'b0;
      od       <= '0;
    end else begin
      if (step) begin
        col <= col_end ? '0 : col + 1'b1;
        if (!flushing) begin
          if (col_end && (rowcnt != 2'd2)) rowcnt <= rowcnt + 2'd1;
          if (in_last) flushing <= 1'b1;
        end else if (col_end) begin
          flushing <= 1'b0;
          rowcnt   <= 2'd0;
        end
      end
      if (rdy_int) begin
        ov    <= pre_valid;
        od    <= nxt;
        olast <= flushing && col_end;
      end
    end
  end
endmodule

// File: rtl/bb_pass.sv
module bb_pass
  import bb_pkg::*;
#(
  parameter int W = 2000,
  parameter int P = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [P*PW-1:0] in_data,
  input  logic            in_last,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [P*PW-1:0] out_data,
  output logic            out_last
);
  logic            h_valid, h_ready, h_last;
  logic [P*PW-1:0] h_data;

  bb_hpass #(.W(W), .P(P)) u_h (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(h_valid), .out_ready(h_ready), .out_data(h_data), .out_last(h_last)
  );

  bb_vpass #(.W(W), .P(P)) u_v (
    .clk(clk), .rst_n(rst_n),
    .in_valid(h_valid), .in_ready(h_ready), .in_data(h_data), .in_last(h_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );
endmodule

// File: rtl/boxblur_top.sv
module boxblur_top
  import bb_pkg::*;
#(
  parameter int W    = 2000,
  parameter int P    = 16,
  parameter int ITER = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [P*PW-1:0] in_data,
  input  logic            in_last,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [P*PW-1:0] out_data,
  output logic            out_last
);
  logic            vld [ITER+1];
  logic            rdy [ITER+1];
  logic            lst [ITER+1];
  logic [P*PW-1:0] dat [ITER+1];

  assign vld[0]    = in_valid;
  assign dat[0]    = in_data;
  assign lst[0]    = in_last;
  assign in_ready  = rdy[0];
  assign out_valid = vld[ITER];
  assign out_data  = dat[ITER];
  assign out_last  = lst[ITER];
  assign rdy[ITER] = out_ready;

  for (genvar k = 0; k < ITER; k++) begin : g_pass
    bb_pass #(.W(W), .P(P)) u_pass (
      .clk(clk), .rst_n(rst_n),
      .in_valid(vld[k]), .in_ready(rdy[k]), .in_data(dat[k]), .in_last(lst[k]),
      .out_valid(vld[k+1]), .out_ready(rdy[k+1]), .out_data(dat[k+1]), .out_last(lst[k+1])
    );
  end
endmodule

// File: rtl/bb_top_chk.sv
module bb_top_chk
  import bb_pkg::*;
#(
  parameter int W = 2000,
  parameter int P = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [P*PW-1:0] out_data,
  input logic            out_last
);
  localparam int BEATS = W / P;
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [CW-1:0] ocol;
  logic [31:0]   pending;
  logic          in_fire, out_fire;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocol    <= '0;
      pending <= '0;
    end else begin
      if (out_fire) ocol <= (ocol == CW'(BEATS - 1)) ? '0 : ocol + 1'b1;
      pending <= pending + (in_fire ? 32'd1 : 32'd0) - (out_fire ? 32'd1 : 32'd0);
    end
  end

  a_r9_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  a_r5_last_at_row_end: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |-> (ocol == CW'(BEATS - 1)));

  a_r5_no_phantom_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |-> (pending != 32'd0));
endmodule

bind boxblur_top bb_top_chk #(.W(W), .P(P)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/boxblur_top_test.sv
module boxblur_top_test;
  localparam int CLK  = 10;
  localparam int W    = 16;
  localparam int ITER = 2;
  localparam int MAXR = 6;
  localparam int NV   = 6;
  // {rows, seed (0 = all 0xFFFF), out_ready percent}
  localparam int TAB [NV][3] = '{
    '{4, 11, 100}, '{1, 22, 50}, '{2, 33, 70},
    '{6, 44, 30},  '{3, 0, 60},  '{5, 55, 90}
  };

  logic clk = 0, rst_n = 0;
  logic in2_valid = 0, in2_last = 0, out2_ready = 0;
  logic in1_valid = 0, in1_last = 0, out1_ready = 0;
  logic [31:0] in2_data = '0;
  logic [15:0] in1_data = '0;
  logic in2_ready, out2_valid, out2_last, in1_ready, out1_valid, out1_last;
  logic [31:0] out2_data;
  logic [15:0] out1_data;

  int errors = 0, checks = 0;
  int img [MAXR][W];
  int ref_img [MAXR][W];

  always #(CLK/2) clk = ~clk;

  boxblur_top #(.W(W), .P(2), .ITER(ITER)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in2_valid), .in_ready(in2_ready),
    .in_data(in2_data), .in_last(in2_last), .out_valid(out2_valid),
    .out_ready(out2_ready), .out_data(out2_data), .out_last(out2_last));

  boxblur_top #(.W(W), .P(1), .ITER(ITER)) uut_p1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in1_valid), .in_ready(in1_ready),
    .in_data(in1_data), .in_last(in1_last), .out_valid(out1_valid),
    .out_ready(out1_ready), .out_data(out1_data), .out_last(out1_last));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build(input int rows, input int seed);
    int c [MAXR][W];
    int t [MAXR][W];
    for (int y = 0; y < rows; y++)
      for (int x = 0; x < W; x++) begin
        img[y][x] = (seed == 0) ? 16'hFFFF : int'($urandom & 32'hFFFF);
        c[y][x] = img[y][x];
      end
    for (int k = 0; k < ITER; k++) begin
      for (int y = 0; y < rows; y++)
        for (int x = 0; x < W; x++)
          t[y][x] = (x == 0 || x == W - 1) ? c[y][x] : (c[y][x-1] + c[y][x] + c[y][x+1]) / 3;
      for (int y = 0; y < rows; y++)
        for (int x = 0; x < W; x++)
          c[y][x] = (y == 0 || y == rows - 1) ? t[y][x] : (t[y-1][x] + t[y][x] + t[y+1][x]) / 3;
    end
    for (int y = 0; y < rows; y++)
      for (int x = 0; x < W; x++) ref_img[y][x] = c[y][x];
  endtask

  function automatic string region(input int rows, input int y, input int x);
    if (y == 0 || y == rows - 1) return "R7/R8 R4";
    if (x == 0 || x == W - 1) return "R7/R8 R2";
    return "R7/R8 R1 R3";
  endfunction

  task automatic drive2(input int rows);
    int n = rows * W / 2;
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      in2_valid = 1;
      in2_data = {img[(2*b+1)/W][(2*b+1)%W][15:0], img[(2*b)/W][(2*b)%W][15:0]};
      in2_last = (b == n - 1);
      #2;
      while (!in2_ready) begin @(negedge clk); #2; end
    end
    @(negedge clk);
    in2_valid = 0; in2_last = 0;
  endtask

  task automatic drive1(input int rows);
    int n = rows * W;
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      in1_valid = 1;
      in1_data = img[b/W][b%W][15:0];
      in1_last = (b == n - 1);
      #2;
      while (!in1_ready) begin @(negedge clk); #2; end
    end
    @(negedge clk);
    in1_valid = 0; in1_last = 0;
  endtask

  task automatic coll2(input int rows, input int pct);
    int n = rows * W / 2;
    int cnt = 0;
    while (cnt < n) begin
      @(negedge clk);
      out2_ready = (int'($urandom % 100) < pct);
      #1;
      if (out2_valid && out2_ready) begin
        for (int l = 0; l < 2; l++) begin
          int p = cnt * 2 + l;
          chk(out2_data[l*16 +: 16] == ref_img[p/W][p%W][15:0], region(rows, p/W, p%W),
              int'(out2_data[l*16 +: 16]), ref_img[p/W][p%W]);
        end
        chk(out2_last == (cnt == n - 1), "R5/R10 last flag P=2", int'(out2_last), int'(cnt == n - 1));
        cnt++;
      end
    end
    @(negedge clk);
    out2_ready = 0;
  endtask

  task automatic coll1(input int rows, input int pct);
    int n = rows * W;
    int cnt = 0;
    while (cnt < n) begin
      @(negedge clk);
      out1_ready = (int'($urandom % 100) < pct);
      #1;
      if (out1_valid && out1_ready) begin
        chk(out1_data == ref_img[cnt/W][cnt%W][15:0], region(rows, cnt/W, cnt%W),
            int'(out1_data), ref_img[cnt/W][cnt%W]);
        chk(out1_last == (cnt == n - 1), "R5/R10 last flag P=1", int'(out1_last), int'(cnt == n - 1));
        cnt++;
      end
    end
    @(negedge clk);
    out1_ready = 0;
  endtask

  task automatic finish_run;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK * 150000);
    errors++; checks++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9: idle state after reset
    chk(out2_valid == 0, "R9 out_valid after reset P=2", int'(out2_valid), 0);
    chk(in2_ready == 1, "R9 in_ready after reset P=2", int'(in2_ready), 1);
    chk(out1_valid == 0, "R9 out_valid after reset P=1", int'(out1_valid), 0);
    chk(in1_ready == 1, "R9 in_ready after reset P=1", int'(in1_ready), 1);

    // Table walk: back-to-back images with no reset between them (R10)
    for (int v = 0; v < NV; v++) begin
      build(TAB[v][0], TAB[v][1]);
      fork
        drive2(TAB[v][0]);
        drive1(TAB[v][0]);
        coll2(TAB[v][0], TAB[v][2]);
        coll1(TAB[v][0], TAB[v][2]);
      join
    end

    // R6: a long stall with output pending must hold the beat steady
    build(3, 77);
    fork
      drive2(3);
      begin
        logic [31:0] held_d;
        logic held_l;
        out2_ready = 0;
        while (!out2_valid) @(negedge clk);
        held_d = out2_data;
        held_l = out2_last;
        for (int i = 0; i < 6; i++) begin
          @(negedge clk);
          chk(out2_valid == 1, "R6 valid held under stall", int'(out2_valid), 1);
          chk(out2_data == held_d, "R6 data held under stall", int'(out2_data), int'(held_d));
          chk(out2_last == held_l, "R6 last held under stall", int'(out2_last), int'(held_l));
        end
        coll2(3, 100);
      end
    join

    finish_run();
  end
endmodule